// File: doc/BRIEF.md
# Load/Store Hazard and Forwarding Control

This block is the hazard control of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It looks at the register numbers and the write, load and store flags held in the pipeline registers. From these it chooses where each execute-stage ALU operand comes from. It chooses where the store-data input of data memory comes from. It also decides when fetch and decode must freeze while a bubble enters execute. It holds no data; the datapath muxes, the register file and the memories sit around it.

When a store's data register is written by the load just ahead of it, no bubble is needed. A load-to-store path in the memory stage carries the freshly read word straight into the write-data port of data memory. A stall is still raised when a load feeds an ALU operand of the next instruction, or the base register of a store, because those values must pass through the ALU. The store-data select is registered. It is computed while the store is still in execute, so it is valid from the first cycle the store occupies the memory stage.

Top module: `hz_unit`

## Requirements
- R1: When the execute stage holds a load with a non-zero destination, and the decode instruction reads that register as an ALU source (rs1 with its use flag set, or rs2 with its use flag set when it is not a store), `pc_hold`, `ifid_hold` and `idex_bubble` are all 1 in that cycle. In a consistent pipeline they are 0 again in the next cycle.
- R2: When the execute stage holds a load and the decode instruction is a store whose only match with the load destination is its data register (rs2), no stall is raised, so the sequence costs no extra cycle.
- R3: When the load destination equals the base register (rs1) of a store in decode, a one-cycle stall is raised.
- R4: `st_data_sel` is 1 in exactly those cycles where the memory stage holds a store, the writeback stage holds a load that writes a non-zero register, and that register is the store's data register. The value is captured at the clock edge that moves the store from execute into memory.
- R5: `fwd_a`/`fwd_b` encode 0 = register file, 1 = writeback-stage value, 2 = memory-stage ALU result. The memory-stage source is used only when that instruction writes a register and is not a load.
- R6: When both the memory-stage and writeback-stage producers write the execute source register, the select is 2 (the newer value).
- R7: Register 0 never causes forwarding, a stall or the store-data bypass.
- R8: A producer whose register-write flag is clear never causes forwarding, a stall or the store-data bypass.
- R9: A store whose data register is written by an older non-load instruction gets its data through `fwd_b` (2 when the producer is one stage ahead, 1 when it is two stages ahead).
- R10: A load followed by an instruction that does not read its destination causes no stall and no forwarding.
- R11: A synchronous active-low reset clears `st_data_sel` at the clock edge, even when a store-after-load pair is in flight. With an idle pipeline every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs1 | input | REG_W | Decode-stage first source register |
| id_rs2 | input | REG_W | Decode-stage second source register |
| id_use_rs1 | input | 1 | Decode instruction reads rs1 |
| id_use_rs2 | input | 1 | Decode instruction reads rs2 |
| id_is_store | input | 1 | Decode instruction is a store (rs1 base, rs2 data) |
| ex_rs1 | input | REG_W | Execute-stage first source register |
| ex_rs2 | input | REG_W | Execute-stage second source register (store data for stores) |
| ex_rd | input | REG_W | Execute-stage destination register |
| ex_regwrite | input | 1 | Execute instruction writes a register |
| ex_memread | input | 1 | Execute instruction is a load |
| ex_memwrite | input | 1 | Execute instruction is a store |
| mem_rd | input | REG_W | Memory-stage destination register |
| mem_regwrite | input | 1 | Memory-stage instruction writes a register |
| mem_memread | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_W | Writeback-stage destination register |
| wb_regwrite | input | 1 | Writeback-stage instruction writes a register |
| fwd_a | output | 2 | Source select for ALU operand A |
| fwd_b | output | 2 | Source select for ALU operand B / store data in execute |
| st_data_sel | output | 1 | Memory write data taken from the writeback-stage load result |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Clear write and memory enables entering execute |

## Verification
The bound checker watches, on every cycle, that register 0 and a producer without a write flag never select a forwarded value. It also checks that a newer memory-stage producer wins over writeback, that a stall only appears behind a load, that a data-only store behind a load never stalls, that a stall never lasts two cycles, and that the store-data bypass only appears with a writing load in writeback. Only the bench's instruction streams can show that whole sequences cost the right number of cycles. These include load-then-use, load-then-store-data, load-then-store-base, unrelated follow-ups and back-to-back writes. The same holds for the registered bypass landing in exactly the store's memory cycle and for its clearing by a reset in mid-flight.

// File: rtl/hz_pkg.sv
// Shared types of the hazard and forwarding control.
// Assumes operand selects are decoded by datapath muxes outside this block.
package hz_pkg;

    // Operand source select: register file, writeback value, memory-stage ALU result.
    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_WB  = 2'd1,
        FWD_MEM = 2'd2
    } fwd_sel_e;

endpackage

// File: rtl/hz_operand_fwd.sv
// Source select for one execute-stage operand.
// Compares the operand register with the memory-stage and writeback-stage
// destinations. The memory-stage result is only offered when that instruction
// is not a load, because a load's word does not exist before the memory read.
// Assumes register 0 is hard-wired zero.
module hz_operand_fwd
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_reg,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_regwrite,
    input  logic             mem_memread,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_regwrite,
    output fwd_sel_e         sel
);

    logic mem_hit;
    logic wb_hit;

    // Pick the newest available producer of src_reg.
    always_comb begin : pick_source
        mem_hit = mem_regwrite && !mem_memread && (mem_rd != '0) && (mem_rd == src_reg);
        wb_hit  = wb_regwrite && (wb_rd != '0) && (wb_rd == src_reg);
        if (mem_hit) begin
            sel = FWD_MEM;
        end else if (wb_hit) begin
            sel = FWD_WB;
        end else begin
            sel = FWD_RF;
        end
    end

endmodule

// File: rtl/hz_load_use.sv
// Load-use stall detection between decode and execute.
// A store's data register (rs2) is excluded: that case is served by the
// memory-stage bypass. A store's base register (rs1) still needs the ALU,
// so it stalls like any other operand.
// Assumes the use flags are clear for fields an instruction does not read.
module hz_load_use #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_use_rs1,
    input  logic             id_use_rs2,
    input  logic             id_is_store,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_regwrite,
    input  logic             ex_memread,
    output logic             stall
);

    logic load_live;
    logic hit_rs1;
    logic hit_rs2;

    // Decide whether the decode instruction must wait one cycle for the load.
    always_comb begin : detect
        load_live = ex_memread && ex_regwrite && (ex_rd != '0);
        hit_rs1   = id_use_rs1 && (id_rs1 == ex_rd);
        hit_rs2   = id_use_rs2 && !id_is_store && (id_rs2 == ex_rd);
        stall     = load_live && (hit_rs1 || hit_rs2);
    end

endmodule

// File: rtl/hz_store_bypass.sv
// Registered memory-to-memory store-data select.
// While a store sits in execute and a load sits in memory, the match is
// known one cycle early. Every instruction in execute moves on to memory at
// the next edge (bubbles only enter execute), so the registered flag lines up
// with the store in memory and the load in writeback.
// Assumes a synchronous active-low reset.
module hz_store_bypass #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] ex_rs2,
    input  logic             ex_memwrite,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_regwrite,
    input  logic             mem_memread,
    output logic             sel
);

    logic sel_next;

    // Store in execute whose data register is the destination of the load ahead.
    always_comb begin : predict
        sel_next = ex_memwrite && mem_memread && mem_regwrite &&
                   (mem_rd != '0) && (mem_rd == ex_rs2);
    end

    // Capture the prediction as the store advances into memory.
    always_ff @(posedge clk) begin : capture
        if (!rst_n) begin
            sel <= 1'b0;
        end else begin
            sel <= sel_next;
        end
    end

endmodule

// File: rtl/hz_unit.sv
// Hazard and forwarding control for a five-stage in-order pipeline.
// Produces the two ALU operand selects, the memory store-data select and the
// freeze/bubble controls. Purely control: no data passes through it.
// Assumes the pipeline registers hand over their fields unchanged each cycle.
module hz_unit
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_use_rs1,
    input  logic             id_use_rs2,
    input  logic             id_is_store,
    input  logic [REG_W-1:0] ex_rs1,
    input  logic [REG_W-1:0] ex_rs2,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_regwrite,
    input  logic             ex_memread,
    input  logic             ex_memwrite,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_regwrite,
    input  logic             mem_memread,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_regwrite,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b,
    output logic             st_data_sel,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble
);

    localparam int NUM_OPS = 2;

    logic [REG_W-1:0] op_src [NUM_OPS];
    fwd_sel_e         op_sel [NUM_OPS];
    logic             stall;

    assign op_src[0] = ex_rs1;
    assign op_src[1] = ex_rs2;

    // One select unit per execute operand.
    generate
        for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
            hz_operand_fwd #(.REG_W(REG_W)) u_fwd (
                .src_reg      (op_src[g]),
                .mem_rd       (mem_rd),
                .mem_regwrite (mem_regwrite),
                .mem_memread  (mem_memread),
                .wb_rd        (wb_rd),
                .wb_regwrite  (wb_regwrite),
                .sel          (op_sel[g])
            );
        end
    endgenerate

    hz_load_use #(.REG_W(REG_W)) u_load_use (
        .id_rs1      (id_rs1),
        .id_rs2      (id_rs2),
        .id_use_rs1  (id_use_rs1),
        .id_use_rs2  (id_use_rs2),
        .id_is_store (id_is_store),
        .ex_rd       (ex_rd),
        .ex_regwrite (ex_regwrite),
        .ex_memread  (ex_memread),
        .stall       (stall)
    );

    hz_store_bypass #(.REG_W(REG_W)) u_st_byp (
        .clk          (clk),
        .rst_n        (rst_n),
        .ex_rs2       (ex_rs2),
        .ex_memwrite  (ex_memwrite),
        .mem_rd       (mem_rd),
        .mem_regwrite (mem_regwrite),
        .mem_memread  (mem_memread),
        .sel          (st_data_sel)
    );

    // Present the selects and fan the stall out to its three consumers.
    always_comb begin : drive_outputs
        fwd_a       = op_sel[0];
        fwd_b       = op_sel[1];
        pc_hold     = stall;
        ifid_hold   = stall;
        idex_bubble = stall;
    end

endmodule

// File: rtl/hz_unit_chk.sv
// Cycle-by-cycle properties of hz_unit, attached with bind.
// Assumes the pipeline fields come from a consistent pipeline.
module hz_unit_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] id_rs1,
    input logic [REG_W-1:0] id_rs2,
    input logic             id_use_rs1,
    input logic             id_is_store,
    input logic [REG_W-1:0] ex_rs1,
    input logic [REG_W-1:0] ex_rs2,
    input logic [REG_W-1:0] ex_rd,
    input logic             ex_regwrite,
    input logic             ex_memread,
    input logic [REG_W-1:0] mem_rd,
    input logic             mem_regwrite,
    input logic             mem_memread,
    input logic [REG_W-1:0] wb_rd,
    input logic             wb_regwrite,
    input logic [1:0]       fwd_a,
    input logic [1:0]       fwd_b,
    input logic             st_data_sel,
    input logic             pc_hold
);

    // R7
    zero_src_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs1 == '0) |-> (fwd_a == 2'd0));

    // R7
    zero_src_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs2 == '0) |-> (fwd_b == 2'd0));

    // R8
    no_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_regwrite && !wb_regwrite) |-> (fwd_a == 2'd0 && fwd_b == 2'd0));

    // R6
    newest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_regwrite && !mem_memread && mem_rd != '0 && mem_rd == ex_rs1)
        |-> (fwd_a == 2'd2));

    // R1
    stall_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (ex_memread && ex_regwrite && ex_rd != '0));

    // R1
    single_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |=> !pc_hold);

    // R2
    data_store_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_memread && id_is_store && id_rs2 == ex_rd &&
         !(id_use_rs1 && id_rs1 == ex_rd)) |-> !pc_hold);

    // R4
    bypass_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_data_sel |-> (wb_regwrite && wb_rd != '0));

endmodule

bind hz_unit hz_unit_chk #(.REG_W(REG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .id_rs1       (id_rs1),
    .id_rs2       (id_rs2),
    .id_use_rs1   (id_use_rs1),
    .id_is_store  (id_is_store),
    .ex_rs1       (ex_rs1),
    .ex_rs2       (ex_rs2),
    .ex_rd        (ex_rd),
    .ex_regwrite  (ex_regwrite),
    .ex_memread   (ex_memread),
    .mem_rd       (mem_rd),
    .mem_regwrite (mem_regwrite),
    .mem_memread  (mem_memread),
    .wb_rd        (wb_rd),
    .wb_regwrite  (wb_regwrite),
    .fwd_a        (fwd_a),
    .fwd_b        (fwd_b),
    .st_data_sel  (st_data_sel),
    .pc_hold      (pc_hold)
);

// File: tb/sim_hz_unit.sv
// Bench: an instruction table runs through a bench-side pipeline model;
// directed tests follow for reset and bypass corner cases.
module sim_hz_unit;

    localparam int REG_W = 5;
    // Instruction word {kind[2:0], rd[4:0], rs1[4:0], rs2[4:0]}
    localparam logic [2:0] K_NOP = 3'd0;
    localparam logic [2:0] K_ALU = 3'd1;
    localparam logic [2:0] K_LD  = 3'd2;
    localparam logic [2:0] K_ST  = 3'd3;
    localparam logic [2:0] K_CMP = 3'd4;
    localparam logic [17:0] NOP = 18'd0;
    localparam int N = 55;

    localparam logic [17:0] PROG [0:N-1] = '{
        {K_LD, 5'd6, 5'd6, 5'd0},   {K_ST, 5'd0, 5'd5, 5'd6},   NOP, NOP, NOP,
        {K_LD, 5'd7, 5'd2, 5'd0},   {K_ALU, 5'd8, 5'd7, 5'd1},  NOP, NOP, NOP,
        {K_LD, 5'd9, 5'd3, 5'd0},   {K_ST, 5'd0, 5'd9, 5'd4},   NOP, NOP, NOP,
        {K_LD, 5'd10, 5'd3, 5'd0},  {K_ALU, 5'd11, 5'd1, 5'd2}, NOP, NOP, NOP,
        {K_ALU, 5'd12, 5'd1, 5'd2}, {K_ALU, 5'd12, 5'd3, 5'd4}, {K_ALU, 5'd13, 5'd12, 5'd12},
        NOP, NOP, NOP,
        {K_ALU, 5'd14, 5'd1, 5'd2}, NOP, {K_ST, 5'd0, 5'd1, 5'd14},
        {K_ALU, 5'd15, 5'd2, 5'd3}, {K_ST, 5'd0, 5'd2, 5'd15},  NOP, NOP, NOP,
        {K_LD, 5'd0, 5'd1, 5'd0},   {K_ALU, 5'd3, 5'd0, 5'd0},  NOP, NOP, NOP,
        {K_CMP, 5'd16, 5'd1, 5'd2}, {K_ALU, 5'd17, 5'd16, 5'd1}, NOP, NOP, NOP,
        {K_LD, 5'd18, 5'd1, 5'd0},  {K_ST, 5'd0, 5'd2, 5'd18},
        {K_LD, 5'd19, 5'd2, 5'd0},  {K_ST, 5'd0, 5'd3, 5'd19},
        {K_LD, 5'd20, 5'd1, 5'd0},  NOP, {K_ALU, 5'd21, 5'd20, 5'd5},
        NOP, NOP, NOP, NOP
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [REG_W-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic id_use_rs1, id_use_rs2, id_is_store;
    logic ex_regwrite, ex_memread, ex_memwrite, mem_regwrite, mem_memread, wb_regwrite;
    logic [1:0] fwd_a, fwd_b;
    logic st_data_sel, pc_hold, ifid_hold, idex_bubble;

    logic [17:0] id_s, ex_s, mem_s, wb_s;
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    hz_unit #(.REG_W(REG_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1),
        .id_use_rs2(id_use_rs2), .id_is_store(id_is_store),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
        .ex_regwrite(ex_regwrite), .ex_memread(ex_memread), .ex_memwrite(ex_memwrite),
        .mem_rd(mem_rd), .mem_regwrite(mem_regwrite), .mem_memread(mem_memread),
        .wb_rd(wb_rd), .wb_regwrite(wb_regwrite),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .st_data_sel(st_data_sel),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
    );

    function automatic logic [2:0] kd(input logic [17:0] w); return w[17:15]; endfunction
    function automatic logic [4:0] rd_of(input logic [17:0] w); return w[14:10]; endfunction
    function automatic logic [4:0] s1_of(input logic [17:0] w); return w[9:5]; endfunction
    function automatic logic [4:0] s2_of(input logic [17:0] w); return w[4:0]; endfunction
    function automatic logic wr_of(input logic [17:0] w);
        return kd(w) == K_ALU || kd(w) == K_LD;
    endfunction
    function automatic logic u1_of(input logic [17:0] w);
        return kd(w) != K_NOP;
    endfunction
    function automatic logic u2_of(input logic [17:0] w);
        return kd(w) == K_ALU || kd(w) == K_ST || kd(w) == K_CMP;
    endfunction

    // Expected operand select from R5, R6, R7, R8.
    function automatic logic [1:0] exp_fwd(input logic [4:0] s);
        if (s != 0 && wr_of(mem_s) && kd(mem_s) != K_LD && rd_of(mem_s) == s) return 2'd2;
        if (s != 0 && wr_of(wb_s) && rd_of(wb_s) == s) return 2'd1;
        return 2'd0;
    endfunction

    // Expected stall from R1, R2, R3, R7.
    function automatic logic exp_stall();
        if (kd(ex_s) != K_LD || rd_of(ex_s) == 0) return 1'b0;
        if (u1_of(id_s) && s1_of(id_s) == rd_of(ex_s)) return 1'b1;
        if (u2_of(id_s) && kd(id_s) != K_ST && s2_of(id_s) == rd_of(ex_s)) return 1'b1;
        return 1'b0;
    endfunction

    // Expected store-data select from R4.
    function automatic logic exp_st();
        return kd(mem_s) == K_ST && kd(wb_s) == K_LD && rd_of(wb_s) != 0 &&
               rd_of(wb_s) == s2_of(mem_s);
    endfunction

    task automatic drive();
        id_rs1 = s1_of(id_s); id_rs2 = s2_of(id_s);
        id_use_rs1 = u1_of(id_s); id_use_rs2 = u2_of(id_s); id_is_store = kd(id_s) == K_ST;
        ex_rs1 = s1_of(ex_s); ex_rs2 = s2_of(ex_s); ex_rd = rd_of(ex_s);
        ex_regwrite = wr_of(ex_s); ex_memread = kd(ex_s) == K_LD; ex_memwrite = kd(ex_s) == K_ST;
        mem_rd = rd_of(mem_s); mem_regwrite = wr_of(mem_s); mem_memread = kd(mem_s) == K_LD;
        wb_rd = rd_of(wb_s); wb_regwrite = wr_of(wb_s);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Store-after-load pair driven directly; optional write-kill and reset.
    task automatic pair_bypass(input logic [4:0] r, input bit kill_wr, input bit do_reset,
                               input int exp, input string tag);
        @(negedge clk);
        id_s = NOP; wb_s = NOP;
        ex_s = {K_ST, 5'd0, 5'd1, r};
        mem_s = {K_LD, r, 5'd2, 5'd0};
        drive();
        if (kill_wr) mem_regwrite = 1'b0;
        if (do_reset) rst_n = 1'b0;
        @(negedge clk);
        wb_s = mem_s; mem_s = ex_s; ex_s = NOP;
        drive();
        if (kill_wr) wb_regwrite = 1'b0;
        #1;
        chk(tag, int'(st_data_sel), exp);
        rst_n = 1'b1;
        @(negedge clk);
        id_s = NOP; ex_s = NOP; mem_s = NOP; wb_s = NOP;
        drive();
    endtask

    initial begin : watchdog
        #2_000_000;
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int pc = 0;
        int stalls = 0;
        int byps = 0;
        rst_n = 1'b0;
        id_s = NOP; ex_s = NOP; mem_s = NOP; wb_s = NOP;
        drive();
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        // R11: idle pipeline under reset
        chk("R11 st_data_sel reset", int'(st_data_sel), 0);
        chk("R11 fwd_a reset", int'(fwd_a), 0);
        chk("R11 fwd_b reset", int'(fwd_b), 0);
        chk("R11 stall reset", int'({pc_hold, ifid_hold, idex_bubble}), 0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < 400; cyc++) begin
            logic st;
            if (pc >= N && id_s == NOP && ex_s == NOP && mem_s == NOP && wb_s == NOP) break;
            @(negedge clk);
            drive();
            #1;
            st = exp_stall();
            chk("R5/R6/R7/R8/R9 fwd_a", int'(fwd_a), int'(exp_fwd(s1_of(ex_s))));
            chk("R5/R6/R7/R8/R9 fwd_b", int'(fwd_b), int'(exp_fwd(s2_of(ex_s))));
            chk("R1/R2/R3/R10 pc_hold", int'(pc_hold), int'(st));
            chk("R1 ifid_hold", int'(ifid_hold), int'(st));
            chk("R1 idex_bubble", int'(idex_bubble), int'(st));
            chk("R4 st_data_sel", int'(st_data_sel), int'(exp_st()));
            if (st) stalls++;
            if (exp_st()) byps++;
            wb_s = mem_s;
            mem_s = ex_s;
            if (st) begin
                ex_s = NOP;
            end else begin
                ex_s = id_s;
                id_s = (pc < N) ? PROG[pc] : NOP;
                pc++;
            end
        end
        // R1 and R3 each cost one bubble; R2 data-only stores cost none.
        chk("R1/R2/R3 total bubbles", stalls, 2);
        chk("R4 bypass cycles", byps, 3);

        pair_bypass(5'd21, 1'b0, 1'b0, 1, "R4 directed pair");
        pair_bypass(5'd21, 1'b0, 1'b1, 0, "R11 reset mid-pair");
        pair_bypass(5'd22, 1'b1, 1'b0, 0, "R8 load without write");
        pair_bypass(5'd0, 1'b0, 1'b0, 0, "R7 register zero pair");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule